// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog that counts in slow ticks taken from a clock prescaler and runs through two timeout windows, one after the other. In the first window, software proves it is alive by pulsing a ping input. Each ping restarts the first window at its full programmed length. If the first window runs out, the block sets a pre-timeout interrupt flag and opens a second window, the grace period. Pings have no effect during the grace period. When the grace period ends, the block sets a timeout interrupt flag and, in the same cycle, drives a one-cycle pulse on one of three reset-request lines.

The reset-scope select picks which line pulses. One line resets the whole chip, one resets only the processor, and one only redirects execution. The processor-only scope is the default. Removing the enable stops everything at once, and it is the only way out of the grace period. Each window length is a 5-bit code n that gives n+1 ticks. The prescaler ratio is a parameter: a production value of about 2^28, a small value for simulation.

Top module: `wdt_two_phase`

## Requirements
- R1: After reset, all interrupt flags and reset-request lines are 0 and the block is idle.
- R2: When enable is sampled high in idle, the pre-timeout flag rises exactly (len1+1)*DIV cycles later, where len1 is the 5-bit first-window code (0 gives 1 tick, 31 gives 32 ticks) and DIV is the prescaler ratio.
- R3: A ping sampled during the first window restarts it, so expiry follows (len1+1)*DIV cycles after the ping. A ping sampled in the same cycle as the expiry wins, and no expiry takes place.
- R4: The second window lasts (len2+1)*DIV cycles from the first-window expiry, and pings during it change nothing.
- R5: The pre-timeout flag (irq_pre_o) is set at the first-window expiry and stays set until it is cleared.
- R6: At the second-window expiry, the timeout flag (irq_to_o) is set and a reset-request line is high for exactly one cycle, both in the same cycle.
- R7: The reset scope code selects the line that pulses: 1 selects rst_chip_o, 2 selects rst_sw_o, and 0 or 3 select rst_cpu_o. At most one line is high at any time.
- R8: Enable sampled low returns the block to idle in any phase. No reset pulse follows, and a later enable starts a fresh first window.
- R9: irq_clr_i bit 0 clears the pre-timeout flag and bit 1 clears the timeout flag. A flag event in the same cycle as its clear leaves the flag set.
- R10: A window length code is sampled when its window is entered. Changing it in the middle of a window does not alter the current window.
- R11: After the reset pulse the block is idle. With enable still high, it starts a new first window on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Watchdog enable; low forces idle |
| ping_i | input | 1 | Keep-alive strobe |
| len1_i | input | 5 | First-window length code (ticks minus one) |
| len2_i | input | 5 | Second-window length code (ticks minus one) |
| scope_i | input | 2 | Reset scope: 0/3 processor, 1 chip, 2 software |
| irq_clr_i | input | 2 | Write-one-to-clear strobes: bit 0 pre-timeout, bit 1 timeout |
| irq_pre_o | output | 1 | Sticky pre-timeout flag |
| irq_to_o | output | 1 | Sticky timeout flag |
| rst_chip_o | output | 1 | Whole-chip reset request pulse |
| rst_cpu_o | output | 1 | Processor-only reset request pulse |
| rst_sw_o | output | 1 | Execution-redirect reset request pulse |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a ping and the tick that ends the first window. The second pair is a flag event and the clear strobe for that flag. The bench lines up a ping exactly on the cycle of the expiry tick and judges that no pre-timeout flag appears and that the window restarts. It then asserts the clear on the expiry cycle and judges that the flag still reads as set. Random traffic with short windows makes both overlaps happen many more times, and each one is compared against a cycle-count model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ONE  = 2'd1,
        PH_TWO  = 2'd2
    } wdt_phase_e;

    localparam int RST_LINES = 3;
    localparam int RST_CHIP  = 0;
    localparam int RST_CPU   = 1;
    localparam int RST_SW    = 2;

    // scope code -> one-hot reset line; 1 chip, 2 software, others processor
    function automatic logic [RST_LINES-1:0] scope_onehot(input logic [1:0] scope);
        logic [RST_LINES-1:0] v;
        v = '0;
        case (scope)
            2'd1:    v[RST_CHIP] = 1'b1;
            2'd2:    v[RST_SW]   = 1'b1;
            default: v[RST_CPU]  = 1'b1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 268435456
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        cnt_d  = cnt_q + 1'b1;
        if (!run_i || restart_i || tick_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R2
    presc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8
    presc_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/wdt_phase_ctrl.sv
module wdt_phase_ctrl
    import wdt_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 ping_i,
    input  logic                 tick_i,
    input  logic [LEN_W-1:0]     len1_i,
    input  logic [LEN_W-1:0]     len2_i,
    input  logic [1:0]           scope_i,
    output logic                 run_o,
    output logic                 restart_o,
    output logic                 pre_evt_o,
    output logic                 to_evt_o,
    output logic [RST_LINES-1:0] pulse_o
);
    typedef struct packed {
        wdt_phase_e           phase;
        logic [LEN_W-1:0]     cnt;
        logic [RST_LINES-1:0] pulse;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{phase: PH_IDLE, cnt: '0, pulse: '0};

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pulse = '0;
        pre_evt_o   = 1'b0;
        to_evt_o    = 1'b0;
        case (ctl_q.phase)
            PH_IDLE: begin
                if (en_i) begin
                    ctl_d.phase = PH_ONE;
                    ctl_d.cnt   = len1_i;
                end
            end
            PH_ONE: begin
                if (!en_i) begin
                    ctl_d = CTL_IDLE;
                end else if (ping_i) begin
                    ctl_d.cnt = len1_i;
                end else if (tick_i) begin
                    if (ctl_q.cnt == '0) begin
                        ctl_d.phase = PH_TWO;
                        ctl_d.cnt   = len2_i;
                        pre_evt_o   = 1'b1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - 1'b1;
                    end
                end
            end
            PH_TWO: begin
                if (!en_i) begin
                    ctl_d = CTL_IDLE;
                end else if (tick_i) begin
                    if (ctl_q.cnt == '0) begin
                        ctl_d       = CTL_IDLE;
                        ctl_d.pulse = scope_onehot(scope_i);
                        to_evt_o    = 1'b1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - 1'b1;
                    end
                end
            end
            default: ctl_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign run_o     = en_i && (ctl_q.phase != PH_IDLE);
    assign restart_o = en_i && ping_i && (ctl_q.phase == PH_ONE);
    assign pulse_o   = ctl_q.pulse;

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pulse != '0) |=> (ctl_q.pulse == '0));

    // R7
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_q.pulse));

    // R4
    ph2_ping_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_TWO && en_i && !tick_i)
            |=> (ctl_q.phase == PH_TWO && $stable(ctl_q.cnt)));

    // R8
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (ctl_q.phase == PH_IDLE && ctl_q.pulse == '0));

    // R11
    pulse_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_d.pulse != '0) |=> (ctl_q.phase == PH_IDLE));

endmodule

// File: rtl/wdt_irq_flags.sv
module wdt_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_comb begin
            flag_d[g] = evt_i[g] || (flag_q[g] && !clr_i[g]);
        end

        // R9
        evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> flag_q[g]);

        // R5
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/wdt_two_phase.sv
module wdt_two_phase
    import wdt_pkg::*;
#(
    parameter int PRESCALE_DIV = 268435456,
    parameter int LEN_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             ping_i,
    input  logic [LEN_W-1:0] len1_i,
    input  logic [LEN_W-1:0] len2_i,
    input  logic [1:0]       scope_i,
    input  logic [1:0]       irq_clr_i,
    output logic             irq_pre_o,
    output logic             irq_to_o,
    output logic             rst_chip_o,
    output logic             rst_cpu_o,
    output logic             rst_sw_o
);
    localparam int NUM_IRQ = 2;

    logic                 run, restart, tick, pre_evt, to_evt;
    logic [RST_LINES-1:0] pulse;
    logic [NUM_IRQ-1:0]   flags;

    wdt_prescaler #(.DIV(PRESCALE_DIV)) presc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .tick_o    (tick)
    );

    wdt_phase_ctrl #(.LEN_W(LEN_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .ping_i    (ping_i),
        .tick_i    (tick),
        .len1_i    (len1_i),
        .len2_i    (len2_i),
        .scope_i   (scope_i),
        .run_o     (run),
        .restart_o (restart),
        .pre_evt_o (pre_evt),
        .to_evt_o  (to_evt),
        .pulse_o   (pulse)
    );

    wdt_irq_flags #(.N(NUM_IRQ)) irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  ({to_evt, pre_evt}),
        .clr_i  (irq_clr_i),
        .flag_o (flags)
    );

    assign irq_pre_o  = flags[0];
    assign irq_to_o   = flags[1];
    assign rst_chip_o = pulse[RST_CHIP];
    assign rst_cpu_o  = pulse[RST_CPU];
    assign rst_sw_o   = pulse[RST_SW];

    // R6
    timeout_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_chip_o || rst_cpu_o || rst_sw_o) |-> irq_to_o);

endmodule

// File: tb/wdt_two_phase_tb_top.sv
module wdt_two_phase_tb_top;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, ping = 1'b0;
    logic [4:0] len1 = '0, len2 = '0;
    logic [1:0] scope = '0, clr = '0;
    logic       irq_pre, irq_to, r_chip, r_cpu, r_sw;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state: 0 idle, 1 first window, 2 second window
    int         m_st = 0;
    int         m_left = 0;
    logic       m_pre = 0, m_to = 0;
    logic [2:0] m_rst = '0;   // {sw, cpu, chip}

    always #4 clk = ~clk;

    wdt_two_phase #(.PRESCALE_DIV(DIV), .LEN_W(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .ping_i(ping),
        .len1_i(len1), .len2_i(len2), .scope_i(scope), .irq_clr_i(clr),
        .irq_pre_o(irq_pre), .irq_to_o(irq_to),
        .rst_chip_o(r_chip), .rst_cpu_o(r_cpu), .rst_sw_o(r_sw)
    );

    task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_line(input logic [1:0] s);
        // R7: 1 chip, 2 software, 0/3 processor
        case (s)
            2'd1:    return 3'b001;
            2'd2:    return 3'b100;
            default: return 3'b010;
        endcase
    endfunction

    // apply inputs for one edge, advance the model, then compare at the negedge
    task automatic cyc(input logic e, input logic p, input logic [4:0] l1,
                       input logic [4:0] l2, input logic [1:0] s, input logic [1:0] c);
        logic pe, te;
        logic [2:0] np;
        en = e; ping = p; len1 = l1; len2 = l2; scope = s; clr = c;
        pe = 0; te = 0; np = '0;
        case (m_st)
            0: if (e) begin m_st = 1; m_left = (int'(l1) + 1) * DIV; end
            1: if (!e) m_st = 0;
               else if (p) m_left = (int'(l1) + 1) * DIV;
               else if (m_left == 1) begin m_st = 2; m_left = (int'(l2) + 1) * DIV; pe = 1; end
               else m_left--;
            default: if (!e) m_st = 0;
               else if (m_left == 1) begin m_st = 0; te = 1; np = exp_line(s); end
               else m_left--;
        endcase
        m_pre = pe | (m_pre & ~c[0]);
        m_to  = te | (m_to & ~c[1]);
        m_rst = np;
        @(negedge clk);
        chk({2'b0, irq_pre}, {2'b0, m_pre}, "R5 pre-timeout flag");
        chk({2'b0, irq_to}, {2'b0, m_to}, "R6 timeout flag");
        chk({r_sw, r_cpu, r_chip}, m_rst, "R7 reset lines");
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) cyc(en, 1'b0, len1, len2, scope, 2'b00);
    endtask

    task automatic to_idle();
        cyc(1'b0, 1'b0, len1, len2, scope, 2'b11);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk({irq_pre, irq_to, r_chip | r_cpu | r_sw}, 3'b000, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        chk({irq_pre, irq_to, r_chip | r_cpu | r_sw}, 3'b000, "R1 idle after reset");

        // R2 + R10: longest first window, length changed mid-window
        cyc(1'b1, 1'b0, 5'd31, 5'd1, 2'd0, 2'b00);
        hold(2);
        len1 = 5'd0;
        hold(32 * DIV - 3);
        chk({2'b0, irq_pre}, 3'b000, "R10 mid-window length change ignored");
        hold(1);
        chk({2'b0, irq_pre}, 3'b001, "R2 32-tick first window expiry");

        // R4: second window, pings ignored, 2 ticks
        for (int i = 0; i < 2 * DIV - 1; i++) cyc(1'b1, 1'b1, 5'd0, 5'd1, 2'd0, 2'b00);
        chk({r_sw, r_cpu, r_chip}, 3'b000, "R4 no pulse before second window ends");
        cyc(1'b1, 1'b1, 5'd0, 5'd1, 2'd0, 2'b00);
        chk({r_sw, r_cpu, r_chip}, 3'b010, "R4 R6 processor pulse after pinged grace");
        cyc(1'b1, 1'b0, 5'd0, 5'd1, 2'd0, 2'b11);
        chk({r_sw, r_cpu, r_chip}, 3'b000, "R11 pulse lasts one cycle");

        // R3: ping on expiry cycle of a 1-tick first window
        to_idle();
        cyc(1'b1, 1'b0, 5'd0, 5'd0, 2'd0, 2'b00);
        hold(DIV - 1);
        cyc(1'b1, 1'b1, 5'd0, 5'd0, 2'd0, 2'b00);
        chk({2'b0, irq_pre}, 3'b000, "R3 ping wins over expiry");
        hold(DIV - 1);
        chk({2'b0, irq_pre}, 3'b000, "R3 restarted window not yet expired");
        // R9: clear on the expiry cycle
        cyc(1'b1, 1'b0, 5'd0, 5'd0, 2'd0, 2'b01);
        chk({2'b0, irq_pre}, 3'b001, "R9 event beats clear");
        cyc(1'b1, 1'b0, 5'd0, 5'd0, 2'd0, 2'b01);
        chk({2'b0, irq_pre}, 3'b000, "R9 clear alone");

        // R8: disable in second window, no pulse
        to_idle();
        cyc(1'b1, 1'b0, 5'd0, 5'd3, 2'd1, 2'b00);
        hold(DIV + 2);
        cyc(1'b0, 1'b0, 5'd0, 5'd3, 2'd1, 2'b00);
        for (int i = 0; i < 5 * DIV; i++) begin
            cyc(1'b0, 1'b0, 5'd0, 5'd3, 2'd1, 2'b00);
            chk({r_sw, r_cpu, r_chip}, 3'b000, "R8 disabled block never pulses");
        end

        // R7 + R11: each scope code, enable held across the pulse
        for (int s = 0; s < 4; s++) begin
            to_idle();
            cyc(1'b1, 1'b0, 5'd0, 5'd0, 2'(s), 2'b11);
            hold(2 * DIV);
            chk({r_sw, r_cpu, r_chip}, exp_line(2'(s)), "R7 scope selects line");
            hold(DIV);
            chk({2'b0, irq_pre}, 3'b001, "R11 restart after pulse");
        end

        // constrained random
        to_idle();
        for (int i = 0; i < 40000; i++) begin
            logic e, p;
            logic [4:0] l1, l2;
            e  = ($urandom_range(0, 199) != 0);
            p  = ($urandom_range(0, 24) == 0);
            l1 = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 3));
            l2 = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 3));
            cyc(e, p, l1, l2, 2'($urandom_range(0, 3)),
                ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule